// File: doc/BRIEF.md
# Partial-Write General Register File

This block is a sixteen-entry, 64-bit general register file with two combinational read ports and one clocked write port. All three ports share one operand size and one extension-prefix flag, in the same way that one instruction has a single operand size and either carries the prefix or does not. Each read port returns the selected slice of its register, zero-extended to 64 bits. The write port merges the new data into the old register contents according to the operand size.

Byte indices 4 to 7 are remapped by the prefix flag. Without the prefix they select the high byte (bits 15:8) of registers 0 to 3. With the prefix they select the low byte of registers 4 to 7. Registers 8 to 15 can only be reached when the prefix is present. Any request that needs one of them while the prefix is absent is flagged as an illegal encoding and does not write.

Register numbering: 0 accumulator, 1 counter, 2 data, 3 base, 4 stack pointer, 5 base pointer, 6 source index, 7 destination index, 8 to 15 extended registers.

Top module: `gpr_file`

## Requirements
- R1: With operand size 3 (quadword), a write replaces all 64 bits of the target register.
- R2: With operand size 2 (doubleword), a write stores data bits 31:0 and clears bits 63:32 of the target register.
- R3: With operand size 1 (word), a write changes bits 15:0 only and keeps bits 63:16 of the target register.
- R4: With operand size 0 (byte), a write changes the selected byte only and keeps the other 56 bits of the register.
- R5: With the prefix flag low and size 0, indices 4, 5, 6 and 7 address bits 15:8 of registers 0, 1, 2 and 3, for both reads and writes.
- R6: With the prefix flag high and size 0, every index 0 to 15 addresses bits 7:0 of the register with that number.
- R7: With the prefix flag low, any index with bit 3 set (8 to 15) on either read port, or on the write port while write enable is high, drives the illegal-encoding output high in the same cycle. Otherwise the output is low.
- R8: While the illegal-encoding output is high, no register changes. A read port whose own index is illegal returns zero.
- R9: Reads are combinational and return the slice zero-extended to 64 bits. A read in the same cycle as a write to the same register returns the old value, and the new value is visible after the clock edge.
- R10: A synchronous active-high reset clears all sixteen registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 doubleword, 3 quadword |
| ext_prefix | input | 1 | Register-extension prefix present |
| rd_idx_a | input | 4 | Read port A register index |
| rd_idx_b | input | 4 | Read port B register index |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 64 | Write data |
| rd_data_a | output | 64 | Read port A data, zero-extended |
| rd_data_b | output | 64 | Read port B data, zero-extended |
| bad_encoding | output | 1 | Illegal register encoding in this request |

## Verification
Random requests mix all four operand sizes with both prefix states, and read-back at quadword size after narrow writes separates a merge that keeps the upper bits from one that clears them. Directed byte writes with indices 4 to 7 are made once with the prefix and once without it, so that a lane written into the wrong register or the wrong byte shows up in a full-width read. Requests that name indices 8 to 15 without the prefix test both the flag and the suppression of the write. A same-register read during a write tells a combinational read of the old value apart from a forwarded new value.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    parameter int GPR_W = 64;
    parameter int GPR_N = 16;
    localparam int IDX_W = $clog2(GPR_N);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_QWORD = 2'd3
    } opsz_e;

    typedef struct packed {
        logic [IDX_W-1:0] phys;  // physical register number
        logic             hi;    // byte lane is bits 15:8
        logic             bad;   // index not reachable without prefix
    } sel_t;

    // Mask of the bits an operand of the given size covers
    function automatic logic [GPR_W-1:0] size_mask(opsz_e sz);
        case (sz)
            SZ_BYTE:  size_mask = {{(GPR_W-8){1'b0}},  8'hFF};
            SZ_WORD:  size_mask = {{(GPR_W-16){1'b0}}, 16'hFFFF};
            SZ_DWORD: size_mask = {{(GPR_W-32){1'b0}}, 32'hFFFF_FFFF};
            default:  size_mask = '1;
        endcase
    endfunction

endpackage

// File: rtl/gpr_index_decode.sv
module gpr_index_decode
    import gpr_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  opsz_e            sz,
    input  logic             prefix,
    output sel_t             sel
);
    // Upper half of the index space needs the prefix
    logic upper;
    logic legacy_hi;

    always_comb begin
        upper     = idx[IDX_W-1];
        legacy_hi = (sz == SZ_BYTE) && !prefix && !upper && idx[IDX_W-2];
        sel.bad   = !prefix && upper;
        sel.hi    = legacy_hi;
        if (legacy_hi)
            sel.phys = {2'b00, idx[IDX_W-3:0]};
        else
            sel.phys = idx;
    end

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import gpr_pkg::*;
(
    input  logic [GPR_N-1:0][GPR_W-1:0] regs,
    input  logic [IDX_W-1:0]            idx,
    input  opsz_e                       sz,
    input  logic                        prefix,
    output logic [GPR_W-1:0]            data,
    output logic                        bad
);
    sel_t             sel;
    logic [GPR_W-1:0] raw;

    gpr_index_decode u_dec (
        .idx    (idx),
        .sz     (sz),
        .prefix (prefix),
        .sel    (sel)
    );

    always_comb begin
        raw  = sel.hi ? (regs[sel.phys] >> 8) : regs[sel.phys];
        data = sel.bad ? '0 : (raw & size_mask(sz));
        bad  = sel.bad;
    end

endmodule

// File: rtl/gpr_merge.sv
module gpr_merge
    import gpr_pkg::*;
(
    input  logic [GPR_W-1:0] old_val,
    input  logic [GPR_W-1:0] wdata,
    input  opsz_e            sz,
    input  logic             hi,
    output logic [GPR_W-1:0] new_val
);
    always_comb begin
        case (sz)
            SZ_QWORD: new_val = wdata;
            SZ_DWORD: new_val = {{(GPR_W-32){1'b0}}, wdata[31:0]};
            SZ_WORD:  new_val = {old_val[GPR_W-1:16], wdata[15:0]};
            default: begin
                if (hi)
                    new_val = {old_val[GPR_W-1:16], wdata[7:0], old_val[7:0]};
                else
                    new_val = {old_val[GPR_W-1:8], wdata[7:0]};
            end
        endcase
    end

endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
#(
    parameter int N_RD = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              op_size,
    input  logic                    ext_prefix,
    input  logic [IDX_W-1:0]        rd_idx_a,
    input  logic [IDX_W-1:0]        rd_idx_b,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [GPR_W-1:0]        wr_data,
    output logic [GPR_W-1:0]        rd_data_a,
    output logic [GPR_W-1:0]        rd_data_b,
    output logic                    bad_encoding
);
    opsz_e                            sz;
    logic [GPR_N-1:0][GPR_W-1:0]      regs;
    logic [N_RD-1:0][IDX_W-1:0]       rd_idx;
    logic [N_RD-1:0][GPR_W-1:0]       rd_data;
    logic [N_RD-1:0]                  rd_bad;
    sel_t                             wsel;
    logic [GPR_W-1:0]                 merged;
    logic                             wr_fire;
    logic [GPR_W-1:0]                 lane_mask;

    assign sz        = opsz_e'(op_size);
    assign rd_idx[0] = rd_idx_a;
    assign rd_idx[1] = rd_idx_b;
    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        gpr_read_port u_port (
            .regs   (regs),
            .idx    (rd_idx[p]),
            .sz     (sz),
            .prefix (ext_prefix),
            .data   (rd_data[p]),
            .bad    (rd_bad[p])
        );
    end

    gpr_index_decode u_wdec (
        .idx    (wr_idx),
        .sz     (sz),
        .prefix (ext_prefix),
        .sel    (wsel)
    );

    gpr_merge u_merge (
        .old_val (regs[wsel.phys]),
        .wdata   (wr_data),
        .sz      (sz),
        .hi      (wsel.hi),
        .new_val (merged)
    );

    assign bad_encoding = (|rd_bad) || (wr_en && wsel.bad);
    assign wr_fire      = wr_en && !bad_encoding;
    assign lane_mask    = wsel.hi ? 64'h0000_0000_0000_FF00 : 64'h0000_0000_0000_00FF;

    always_ff @(posedge clk) begin
        if (rst)
            regs <= '0;
        else if (wr_fire)
            regs[wsel.phys] <= merged;
    end

    // R1: full replacement at quadword size
    a_r1_qword_full: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && sz == SZ_QWORD) |=> regs[$past(wsel.phys)] == $past(wr_data));

    // R2: doubleword write clears the upper half
    a_r2_dword_zext: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && sz == SZ_DWORD)
        |=> regs[$past(wsel.phys)] == {32'b0, $past(wr_data[31:0])});

    // R3: word write keeps bits 63:16
    a_r3_word_keeps_upper: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && sz == SZ_WORD)
        |=> regs[$past(wsel.phys)][GPR_W-1:16] == $past(regs[wsel.phys][GPR_W-1:16]));

    // R4: byte write touches only its lane
    a_r4_byte_lane_only: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && sz == SZ_BYTE)
        |=> ((regs[$past(wsel.phys)] ^ $past(regs[wsel.phys])) & ~$past(lane_mask)) == '0);

    // R8: illegal request leaves the file unchanged
    a_r8_bad_no_write: assert property (@(posedge clk) disable iff (rst)
        bad_encoding |=> $stable(regs));

endmodule

// File: tb/gpr_file_bench.sv
`timescale 1ns/1ps
module gpr_file_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_size = 2'd3;
    logic        ext_prefix = 1'b1;
    logic [3:0]  rd_idx_a = '0, rd_idx_b = '0, wr_idx = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data_a, rd_data_b;
    logic        bad_encoding;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] mdl [16];

    always #4 clk = ~clk;

    gpr_file u_gpr_file (
        .clk(clk), .rst(rst), .op_size(op_size), .ext_prefix(ext_prefix),
        .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_data_a(rd_data_a),
        .rd_data_b(rd_data_b), .bad_encoding(bad_encoding)
    );

    function automatic logic [63:0] szmask(logic [1:0] sz);
        case (sz)
            2'd0: return 64'hFF;
            2'd1: return 64'hFFFF;
            2'd2: return 64'hFFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    function automatic logic [63:0] m_read(logic [3:0] idx, logic [1:0] sz, logic pfx);
        if (!pfx && idx[3]) return '0;
        if (sz == 2'd0 && !pfx && idx[2]) return (mdl[idx - 4] >> 8) & 64'hFF;
        return mdl[idx] & szmask(sz);
    endfunction

    function automatic logic m_bad(logic [3:0] ia, logic [3:0] ib, logic we,
                                   logic [3:0] iw, logic pfx);
        return !pfx && (ia[3] || ib[3] || (we && iw[3]));
    endfunction

    task automatic m_write(logic [3:0] idx, logic [1:0] sz, logic pfx, logic [63:0] d);
        logic [3:0] p;
        p = idx;
        case (sz)
            2'd3: mdl[p] = d;
            2'd2: mdl[p] = {32'b0, d[31:0]};
            2'd1: mdl[p] = {mdl[p][63:16], d[15:0]};
            default: begin
                if (!pfx && idx[2]) begin
                    p = idx - 4;
                    mdl[p] = {mdl[p][63:16], d[7:0], mdl[p][7:0]};
                end else
                    mdl[p] = {mdl[p][63:8], d[7:0]};
            end
        endcase
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One request: drive at falling edge, check reads and flag, then clock it
    task automatic op(logic [1:0] sz, logic pfx, logic [3:0] ia, logic [3:0] ib,
                      logic we, logic [3:0] iw, logic [63:0] d, string tag);
        logic b;
        @(negedge clk);
        op_size = sz; ext_prefix = pfx; rd_idx_a = ia; rd_idx_b = ib;
        wr_en = we; wr_idx = iw; wr_data = d;
        #1;
        b = m_bad(ia, ib, we, iw, pfx);
        check({tag, " R9 read A"}, rd_data_a, m_read(ia, sz, pfx));
        check({tag, " R9 read B"}, rd_data_b, m_read(ib, sz, pfx));
        check({tag, " R7 flag"}, {63'b0, bad_encoding}, {63'b0, b});
        @(posedge clk);
        if (we && !b) m_write(iw, sz, pfx, d);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic peek(logic [3:0] idx, string tag);
        @(negedge clk);
        op_size = 2'd3; ext_prefix = 1'b1; rd_idx_a = idx; wr_en = 1'b0;
        #1;
        check(tag, rd_data_a, mdl[idx]);
    endtask

    bit done = 0;

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        for (int i = 0; i < 16; i++) mdl[i] = 64'hDEAD;  // garbage before reset
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        for (int i = 0; i < 16; i++) peek(i[3:0], "R10 reset clears");

        // R1 / R2 / R3 / R4 directed merges
        op(2'd3, 1, 0, 0, 1, 0, 64'h1122_3344_5566_7788, "R1 qword");
        peek(0, "R1 qword readback");
        op(2'd1, 1, 0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_ABCD, "R3 word");
        peek(0, "R3 word keeps upper");
        op(2'd0, 1, 0, 0, 1, 0, 64'h0000_0000_0000_00EE, "R4 byte");
        peek(0, "R4 byte keeps others");
        op(2'd2, 1, 0, 0, 1, 0, 64'hAAAA_AAAA_1357_9BDF, "R2 dword");
        peek(0, "R2 dword zero-extends");

        // R5: legacy high byte without prefix
        op(2'd3, 1, 0, 0, 1, 2, 64'h0102_0304_0506_0708, "R5 setup");
        op(2'd3, 1, 0, 0, 1, 6, 64'h1112_1314_1516_1718, "R5 setup");
        op(2'd0, 0, 6, 6, 1, 6, 64'h0000_0000_0000_005A, "R5 hi byte write");
        peek(2, "R5 hi byte lands in reg 2 bits 15:8");
        peek(6, "R5 reg 6 untouched");
        // R6: same index with prefix hits reg 6 low byte
        op(2'd0, 1, 6, 2, 1, 6, 64'h0000_0000_0000_00C3, "R6 low byte write");
        peek(6, "R6 low byte of reg 6");
        peek(2, "R6 reg 2 untouched");
        op(2'd0, 1, 13, 13, 1, 13, 64'h77, "R6 extended byte");
        peek(13, "R6 reg 13 low byte");

        // R7 / R8: illegal encodings
        op(2'd0, 0, 4, 9, 1, 1, 64'h99, "R8 bad read B blocks write");
        peek(1, "R8 reg 1 unchanged");
        op(2'd2, 0, 0, 1, 1, 12, 64'h4444_4444, "R8 bad write index");
        peek(12, "R8 reg 12 unchanged");
        peek(4, "R8 reg 4 unchanged");

        // R9: same-cycle read returns the old value
        op(2'd3, 1, 3, 3, 1, 3, 64'hCAFE_F00D_0000_0001, "R9 same-cycle");
        peek(3, "R9 new value after edge");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] sz;
            logic pfx;
            logic [3:0] ia, ib, iw;
            logic we;
            logic [63:0] d;
            sz  = 2'($urandom);
            pfx = 1'($urandom);
            ia  = 4'($urandom); ib = 4'($urandom); iw = 4'($urandom);
            if (!pfx && ($urandom % 8) != 0) begin
                ia[3] = 1'b0; ib[3] = 1'b0; iw[3] = 1'b0;
            end
            we = ($urandom % 4) != 0;
            d  = {$urandom, $urandom};
            op(sz, pfx, ia, ib, we, iw, d, "R1-R8 random");
        end
        for (int i = 0; i < 16; i++) peek(i[3:0], "R10 final sweep R1 R2 R3 R4");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule